// File: doc/BRIEF.md
# Queue Ownership Map with Reset Timeout

This block keeps a table that says, for each of 64 hardware queues, whether the queue is in service and which function owns it. Entries 0 to 31 form the uplink half and entries 32 to 63 form the downlink half. A register-write port can set each entry one at a time. A build engine can also fill the whole table from per-function queue counts. In that case each half is handed out in contiguous runs, with function 0 first and the other functions following in ascending order. A physical-function-only mode gives every queue to the physical function. A lookup port answers, in the same cycle, with the owner of any queue. It reports no owner at all until software has written the ready flag.

The block also times a function-level reset. A request restarts a timer that counts coarse units, each one a fixed number of clock cycles set by the `TICK_DIV` parameter. If no acknowledge arrives before the programmed number of units has passed, the block raises a timeout. A reset request also withdraws the ready flag, so software must rebuild or confirm the map before lookups resume.

The build engine is a two-state machine:
- In `B_IDLE`, an accepted `cfg_start` moves it to `B_FILL`. A `cfg_start` whose counts overflow keeps it in `B_IDLE` and sets the error flag.
- `B_FILL` writes one entry per cycle and returns to `B_IDLE` after entry 63.

The timer is a three-state machine:
- A request moves it from any state to `T_WAIT`.
- From `T_WAIT`, an acknowledge moves it to `T_IDLE`, and reaching the limit moves it to `T_EXPIRED`.
- `T_EXPIRED` holds until the next request.

Top module: `queue_owner_map`

## Requirements
- R1: A write to byte address 4·i (i = 0..63, address bit 8 clear), with data other than all ones, stores bit 0 as the enable and bits 23:16 as the owner code of entry i. Once the ready flag is set, a lookup of i returns that entry.
- R2: Writing 32'hFFFF_FFFF to an entry clears it, and a lookup of that entry then reports not valid.
- R3: A lookup is valid only if the entry is enabled and its owner code is legal. The legal codes are 8'h00 (physical function) and 8'h80 to 8'h87 (function 0 to 7). Whenever a lookup is not valid, the owner output is 0.
- R4: The ready flag is bit 0 of a write to byte address 9'h100. While the flag is 0, every lookup reports not valid with owner 0.
- R5: A build in function mode assigns uplink entries 0..31 and downlink entries 32..63 separately. Within each half, function f (counts in `cfg_ul_cnt`/`cfg_dl_cnt` bits 6f+5:6f) gets a contiguous run directly after the runs of functions 0..f-1, with owner code 8'h80+f. All remaining entries are cleared. `cfg_busy` is high for exactly 64 cycles.
- R6: A build in physical-function mode enables all 64 entries with owner 8'h00 and ignores the counts, even counts that would overflow.
- R7: In function mode, a start whose uplink or downlink counts sum to more than 32 sets `cfg_error`, leaves the table unchanged and does not raise `cfg_busy`. The next accepted start clears `cfg_error`.
- R8: Register writes, whether to the table, the ready flag or the timeout, have no effect while `cfg_busy` is high.
- R9: The timeout limit is bits 15:0 of a write to byte address 9'h104, counted in units of `TICK_DIV` cycles. `flr_timeout` rises limit·TICK_DIV+1 cycles after the clock edge that samples `flr_req`, unless an acknowledge arrives first. It then stays high until the next request.
- R10: An `flr_ack` seen while waiting stops the timer without a timeout. This holds even in the very cycle the limit is reached.
- R11: `flr_req` clears the ready flag, and it wins over a ready-flag write in the same cycle. It also clears `flr_timeout` and restarts the timer.
- R12: After reset all entries are cleared and the ready flag, `cfg_busy`, `cfg_error` and `flr_timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Byte address of the write |
| wr_data | input | 32 | Write data |
| lk_idx | input | 6 | Queue index to look up |
| lk_valid | output | 1 | Queue is in service and has a legal owner |
| lk_owner | output | 8 | Owner code of the queue, 0 when not valid |
| cfg_start | input | 1 | Start a table build |
| cfg_pf_mode | input | 1 | Build gives every queue to the physical function |
| cfg_ul_cnt | input | 48 | Uplink queue count per function, 6 bits each |
| cfg_dl_cnt | input | 48 | Downlink queue count per function, 6 bits each |
| cfg_busy | output | 1 | Build in progress |
| cfg_error | output | 1 | Last start was rejected for overflow |
| flr_req | input | 1 | Function-level reset request pulse |
| flr_ack | input | 1 | Reset completion acknowledge |
| flr_timeout | output | 1 | Reset was not acknowledged in time |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a reset request and a ready-flag write. The bench drives both in the same cycle while a valid entry is held on the lookup port. It then requires the lookup to read invalid, and to read valid again only after a later, separate ready write.

The second pair is an acknowledge and the timer reaching its limit. With a limit of one unit, the bench places the acknowledge in exactly the cycle after the unit counter reaches the limit. It then requires `flr_timeout` to stay low for many cycles afterwards.

// File: rtl/qmap_pkg.sv
package qmap_pkg;
    localparam int NUM_Q      = 64;
    localparam int HALF_Q     = NUM_Q / 2;
    localparam int QIDX_W     = $clog2(NUM_Q);
    localparam int NUM_FN     = 8;
    localparam int FN_W       = $clog2(NUM_FN);
    localparam int CNT_W      = $clog2(HALF_Q + 1);
    localparam int SUM_W      = CNT_W + FN_W;
    localparam int OWN_W      = 8;
    localparam int ADDR_W     = 9;
    localparam int TMO_W      = 16;
    localparam logic [ADDR_W-1:0] READY_ADDR = 9'h100;
    localparam logic [ADDR_W-1:0] TMO_ADDR   = 9'h104;
    localparam logic [OWN_W-1:0]  FN_BASE    = 8'h80;
    localparam logic [31:0]       CLEAR_WORD = 32'hFFFF_FFFF;

    typedef struct packed {
        logic             en;
        logic [OWN_W-1:0] owner;
    } qent_t;
endpackage

// File: rtl/qmap_table.sv
module qmap_table
    import qmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [QIDX_W-1:0] widx,
    input  qent_t             wdata,
    input  logic              ready_we,
    input  logic              ready_val,
    input  logic              flr_clr,
    input  logic [QIDX_W-1:0] lk_idx,
    output logic              lk_valid,
    output logic [OWN_W-1:0]  lk_owner
);
    qent_t tbl_q [NUM_Q];
    logic  ready_q;
    qent_t rd;
    logic  legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_Q; i++) tbl_q[i] <= '0;
        end else if (we) begin
            tbl_q[widx] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ready_q <= 1'b0;
        else if (flr_clr)  ready_q <= 1'b0;
        else if (ready_we) ready_q <= ready_val;
    end

    always_comb begin
        rd       = tbl_q[lk_idx];
        legal    = (rd.owner == '0) || (rd.owner[OWN_W-1:FN_W] == FN_BASE[OWN_W-1:FN_W]);
        lk_valid = ready_q && rd.en && legal;
        lk_owner = lk_valid ? rd.owner : '0;
    end

    AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (tbl_q[$past(widx)] == $past(wdata)));   // R1
endmodule

// File: rtl/qmap_builder.sv
module qmap_builder
    import qmap_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    pf_mode,
    input  logic [NUM_FN*CNT_W-1:0] ul_cnt,
    input  logic [NUM_FN*CNT_W-1:0] dl_cnt,
    output logic                    busy,
    output logic                    err,
    output logic                    we,
    output logic [QIDX_W-1:0]       widx,
    output qent_t                   wdata
);
    typedef enum logic {B_IDLE, B_FILL} bstate_t;
    bstate_t state_q, state_d;

    logic [CNT_W-1:0]  ul_q [NUM_FN];
    logic [CNT_W-1:0]  dl_q [NUM_FN];
    logic              pf_q;
    logic [QIDX_W-1:0] q_q;
    logic              err_q;
    logic [SUM_W-1:0]  ul_sum, dl_sum;
    logic              ovf, accept;

    always_comb begin
        ul_sum = '0;
        dl_sum = '0;
        for (int f = 0; f < NUM_FN; f++) begin
            ul_sum = ul_sum + SUM_W'(ul_cnt[f*CNT_W +: CNT_W]);
            dl_sum = dl_sum + SUM_W'(dl_cnt[f*CNT_W +: CNT_W]);
        end
        ovf    = (ul_sum > SUM_W'(HALF_Q)) || (dl_sum > SUM_W'(HALF_Q));
        accept = (state_q == B_IDLE) && start && (pf_mode || !ovf);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            B_IDLE: if (accept) state_d = B_FILL;
            B_FILL: if (q_q == QIDX_W'(NUM_Q - 1)) state_d = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= B_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_q  <= 1'b0;
            q_q   <= '0;
            err_q <= 1'b0;
            for (int f = 0; f < NUM_FN; f++) begin
                ul_q[f] <= '0;
                dl_q[f] <= '0;
            end
        end else if (state_q == B_IDLE) begin
            if (start && !accept) begin
                err_q <= 1'b1;
            end else if (accept) begin
                err_q <= 1'b0;
                pf_q  <= pf_mode;
                q_q   <= '0;
                for (int f = 0; f < NUM_FN; f++) begin
                    ul_q[f] <= ul_cnt[f*CNT_W +: CNT_W];
                    dl_q[f] <= dl_cnt[f*CNT_W +: CNT_W];
                end
            end
        end else begin
            q_q <= q_q + 1'b1;
        end
    end

    // Owner search for the current entry: walk functions in order over prefix sums.
    logic [SUM_W-1:0]  acc;
    logic [SUM_W-1:0]  pos;
    logic [CNT_W-1:0]  cnt;
    logic              hit;
    logic [FN_W-1:0]   fn;

    always_comb begin
        acc = '0;
        hit = 1'b0;
        fn  = '0;
        pos = SUM_W'(q_q[QIDX_W-2:0]);
        for (int f = 0; f < NUM_FN; f++) begin
            cnt = q_q[QIDX_W-1] ? dl_q[f] : ul_q[f];
            if (!hit && pos >= acc && pos < acc + SUM_W'(cnt)) begin
                hit = 1'b1;
                fn  = FN_W'(f);
            end
            acc = acc + SUM_W'(cnt);
        end
    end

    always_comb begin
        busy = (state_q == B_FILL);
        err  = err_q;
        we   = busy;
        widx = q_q;
        if (pf_q) begin
            wdata.en    = 1'b1;
            wdata.owner = '0;
        end else begin
            wdata.en    = hit;
            wdata.owner = hit ? (FN_BASE | OWN_W'(fn)) : '0;
        end
    end

    AST_OVF_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == B_IDLE && start && !pf_mode && ovf) |=> (!busy && err));   // R7
endmodule

// File: rtl/qmap_flr_timer.sv
module qmap_flr_timer
    import qmap_pkg::*;
#(
    parameter int TICK_DIV = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             ack,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    typedef enum logic [1:0] {T_IDLE, T_WAIT, T_EXPIRED} tstate_t;
    tstate_t          state_q, state_d;
    logic [PRE_W-1:0] pre_q;
    logic [TMO_W-1:0] units_q;

    always_comb begin
        state_d = state_q;
        if (req) begin
            state_d = T_WAIT;
        end else begin
            unique case (state_q)
                T_IDLE:    state_d = T_IDLE;
                T_WAIT:    if (ack)                  state_d = T_IDLE;
                           else if (units_q == limit) state_d = T_EXPIRED;
                T_EXPIRED: state_d = T_EXPIRED;
                default:   state_d = T_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            units_q <= '0;
        end else if (req) begin
            pre_q   <= '0;
            units_q <= '0;
        end else if (state_q == T_WAIT && state_d == T_WAIT) begin
            if (pre_q == PRE_LAST) begin
                pre_q   <= '0;
                units_q <= units_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    always_comb expired = (state_q == T_EXPIRED);

    AST_ACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_WAIT && ack && !req) |=> !expired);   // R10
    AST_REQ_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !expired);   // R11
endmodule

// File: rtl/queue_owner_map.sv
module queue_owner_map
    import qmap_pkg::*;
#(
    parameter int TICK_DIV = 4096
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [31:0]             wr_data,
    input  logic [QIDX_W-1:0]       lk_idx,
    output logic                    lk_valid,
    output logic [OWN_W-1:0]        lk_owner,
    input  logic                    cfg_start,
    input  logic                    cfg_pf_mode,
    input  logic [NUM_FN*CNT_W-1:0] cfg_ul_cnt,
    input  logic [NUM_FN*CNT_W-1:0] cfg_dl_cnt,
    output logic                    cfg_busy,
    output logic                    cfg_error,
    input  logic                    flr_req,
    input  logic                    flr_ack,
    output logic                    flr_timeout
);
    logic              reg_we, tbl_reg_we;
    qent_t             reg_ent;
    logic              b_we;
    logic [QIDX_W-1:0] b_idx;
    qent_t             b_ent;
    logic              t_we;
    logic [QIDX_W-1:0] t_idx;
    qent_t             t_ent;
    logic [TMO_W-1:0]  limit_q;

    always_comb begin
        reg_we     = wr_en && !cfg_busy;
        tbl_reg_we = reg_we && !wr_addr[ADDR_W-1];
        if (wr_data == CLEAR_WORD) begin
            reg_ent = '0;
        end else begin
            reg_ent.en    = wr_data[0];
            reg_ent.owner = wr_data[23:16];
        end
        t_we  = b_we || tbl_reg_we;
        t_idx = b_we ? b_idx : wr_addr[QIDX_W+1:2];
        t_ent = b_we ? b_ent : reg_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              limit_q <= '0;
        else if (reg_we && wr_addr == TMO_ADDR)  limit_q <= wr_data[TMO_W-1:0];
    end

    qmap_builder u_builder (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cfg_start),
        .pf_mode (cfg_pf_mode),
        .ul_cnt  (cfg_ul_cnt),
        .dl_cnt  (cfg_dl_cnt),
        .busy    (cfg_busy),
        .err     (cfg_error),
        .we      (b_we),
        .widx    (b_idx),
        .wdata   (b_ent)
    );

    qmap_table u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (t_we),
        .widx      (t_idx),
        .wdata     (t_ent),
        .ready_we  (reg_we && wr_addr == READY_ADDR),
        .ready_val (wr_data[0]),
        .flr_clr   (flr_req),
        .lk_idx    (lk_idx),
        .lk_valid  (lk_valid),
        .lk_owner  (lk_owner)
    );

    qmap_flr_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (flr_req),
        .ack     (flr_ack),
        .limit   (limit_q),
        .expired (flr_timeout)
    );

    AST_FLR_BLOCKS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        flr_req |=> !lk_valid);   // R11
    AST_BUSY_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_busy |-> !cfg_error);   // R7
endmodule

// File: tb/test_queue_owner_map.sv
module test_queue_owner_map;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  lk_idx = '0;
    logic        lk_valid;
    logic [7:0]  lk_owner;
    logic        cfg_start = 1'b0;
    logic        cfg_pf_mode = 1'b0;
    logic [47:0] cfg_ul_cnt = '0;
    logic [47:0] cfg_dl_cnt = '0;
    logic        cfg_busy, cfg_error;
    logic        flr_req = 1'b0;
    logic        flr_ack = 1'b0;
    logic        flr_timeout;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    queue_owner_map #(.TICK_DIV(DIV)) i_queue_owner_map (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_owner(lk_owner),
        .cfg_start(cfg_start), .cfg_pf_mode(cfg_pf_mode),
        .cfg_ul_cnt(cfg_ul_cnt), .cfg_dl_cnt(cfg_dl_cnt),
        .cfg_busy(cfg_busy), .cfg_error(cfg_error),
        .flr_req(flr_req), .flr_ack(flr_ack), .flr_timeout(flr_timeout)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input string tag, input int idx, input logic v, input logic [7:0] o);
        @(negedge clk);
        lk_idx = 6'(idx);
        #1;
        check({tag, " valid"}, 32'(lk_valid), 32'(v));
        check({tag, " owner"}, 32'(lk_owner), 32'(o));
    endtask

    task automatic start_build(input logic pf);
        @(negedge clk);
        cfg_pf_mode = pf; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
    endtask

    task automatic wait_idle();
        while (cfg_busy) @(negedge clk);
    endtask

    task automatic t_reset();
        look("R12 idx0", 0, 1'b0, 8'h00);
        look("R12 idx63", 63, 1'b0, 8'h00);
        check("R12 busy", 32'(cfg_busy), 0);
        check("R12 error", 32'(cfg_error), 0);
        check("R12 timeout", 32'(flr_timeout), 0);
    endtask

    task automatic t_write_lookup();
        wr(9'h01C, 32'h0083_0001);
        look("R4 gated before ready", 7, 1'b0, 8'h00);
        wr(9'h100, 32'h1);
        look("R1 idx7", 7, 1'b1, 8'h83);
        wr(9'h0FC, 32'h0000_0001);
        look("R1 pf owner idx63", 63, 1'b1, 8'h00);
        wr(9'h01C, 32'h0042_0001);
        look("R3 illegal owner", 7, 1'b0, 8'h00);
        wr(9'h01C, 32'h0088_0001);
        look("R3 owner 88", 7, 1'b0, 8'h00);
        wr(9'h01C, 32'h0087_0001);
        look("R3 owner 87", 7, 1'b1, 8'h87);
        wr(9'h01C, 32'h0080_0000);
        look("R3 not enabled", 7, 1'b0, 8'h00);
        wr(9'h100, 32'h0);
        wr(9'h0FC, 32'h0000_0001);
        look("R4 ready cleared", 63, 1'b0, 8'h00);
        wr(9'h100, 32'h1);
    endtask

    task automatic t_clear();
        wr(9'h050, 32'h0085_0001);
        look("R2 before clear", 20, 1'b1, 8'h85);
        wr(9'h050, 32'hFFFF_FFFF);
        look("R2 after clear", 20, 1'b0, 8'h00);
    endtask

    task automatic t_build_vf();
        int ul [8] = '{4, 2, 0, 3, 0, 0, 0, 0};
        int dl [8] = '{1, 0, 0, 0, 0, 0, 0, 31};
        int ok;
        wr(9'h050, 32'h0081_0001);
        for (int f = 0; f < 8; f++) begin
            cfg_ul_cnt[f*6 +: 6] = 6'(ul[f]);
            cfg_dl_cnt[f*6 +: 6] = 6'(dl[f]);
        end
        start_build(1'b0);
        check("R5 busy rises", 32'(cfg_busy), 1);
        repeat (63) @(posedge clk);
        #1 check("R5 busy at cycle 64", 32'(cfg_busy), 1);
        @(posedge clk);
        #1 check("R5 busy falls", 32'(cfg_busy), 0);
        ok = 1;
        for (int h = 0; h < 2; h++) begin
            int base = 0;
            for (int f = 0; f < 8; f++) begin
                int n = h ? dl[f] : ul[f];
                for (int k = 0; k < n; k++) begin
                    @(negedge clk); lk_idx = 6'(h*32 + base + k); #1;
                    if (!(lk_valid === 1'b1 && lk_owner === 8'(8'h80 + f))) begin
                        ok = 0;
                        $display("FAIL R5 idx %0d actual=%0b/%0h expected=1/%0h",
                                 h*32 + base + k, lk_valid, lk_owner, 8'h80 + f);
                    end
                end
                base += n;
            end
            for (int q = base; q < 32; q++) begin
                @(negedge clk); lk_idx = 6'(h*32 + q); #1;
                if (lk_valid !== 1'b0) begin
                    ok = 0;
                    $display("FAIL R5 idx %0d actual=%0b expected=0", h*32 + q, lk_valid);
                end
            end
        end
        total++;
        if (!ok) bad++;
        check("R7 error after good build", 32'(cfg_error), 0);
    endtask

    task automatic t_overflow();
        cfg_ul_cnt = '0; cfg_dl_cnt = '0;
        cfg_ul_cnt[0 +: 6] = 6'd32;
        cfg_ul_cnt[6 +: 6] = 6'd1;
        start_build(1'b0);
        check("R7 no busy", 32'(cfg_busy), 0);
        check("R7 error set", 32'(cfg_error), 1);
        look("R7 table kept idx4", 4, 1'b1, 8'h81);
        look("R7 table kept idx20", 20, 1'b0, 8'h00);
    endtask

    task automatic t_build_pf();
        start_build(1'b1);
        check("R6 busy", 32'(cfg_busy), 1);
        check("R7 error cleared", 32'(cfg_error), 0);
        wr(9'h014, 32'h0081_0001);
        wr(9'h100, 32'h0);
        wr(9'h104, 32'h0000_0002);
        wait_idle();
        look("R8 table write ignored", 5, 1'b1, 8'h00);
        look("R6 idx31", 31, 1'b1, 8'h00);
        look("R6 idx32", 32, 1'b1, 8'h00);
        look("R6 idx20", 20, 1'b1, 8'h00);
    endtask

    task automatic t_timeout();
        wr(9'h104, 32'h0000_0003);
        @(negedge clk); flr_req = 1'b1;
        @(posedge clk); #1 flr_req = 1'b0;
        repeat (12) @(posedge clk);
        #1 check("R9 not yet", 32'(flr_timeout), 0);
        @(posedge clk);
        #1 check("R9 expired", 32'(flr_timeout), 1);
        repeat (10) @(posedge clk);
        #1 check("R9 sticky", 32'(flr_timeout), 1);
        look("R11 ready cleared by req", 0, 1'b0, 8'h00);
        @(negedge clk); flr_req = 1'b1;
        @(posedge clk); #1 flr_req = 1'b0;
        check("R11 req clears timeout", 32'(flr_timeout), 0);
        @(negedge clk); flr_ack = 1'b1;
        @(negedge clk); flr_ack = 1'b0;
    endtask

    task automatic t_ack_race();
        wr(9'h104, 32'h0000_0001);
        @(negedge clk); flr_req = 1'b1;
        @(posedge clk); #1 flr_req = 1'b0;
        repeat (4) @(posedge clk);
        #1 flr_ack = 1'b1;
        @(posedge clk);
        #1 flr_ack = 1'b0;
        check("R10 ack at limit", 32'(flr_timeout), 0);
        repeat (20) @(posedge clk);
        #1 check("R10 stays stopped", 32'(flr_timeout), 0);
    endtask

    task automatic t_ready_race();
        wr(9'h100, 32'h1);
        look("R11 valid before race", 0, 1'b1, 8'h00);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'h100; wr_data = 32'h1; flr_req = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; flr_req = 1'b0;
        look("R11 req beats ready write", 0, 1'b0, 8'h00);
        @(negedge clk); flr_ack = 1'b1;
        @(negedge clk); flr_ack = 1'b0;
        wr(9'h100, 32'h1);
        look("R4 ready rewritten", 0, 1'b1, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_write_lookup();
        t_clear();
        t_build_vf();
        t_overflow();
        t_build_pf();
        t_timeout();
        t_ack_race();
        t_ready_race();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule